// File: doc/BRIEF.md
# Converter Control and Result Registers

This block is the register front end of an analog-to-digital converter. A CPU writes one control word that selects an input channel, turns continuous conversion on or off and enables an interrupt. Every such write starts a conversion on the selected channel. The converter core is modelled as three signals: a one-cycle start pulse, a one-cycle done pulse and a result bus. The block captures each result in a data register, sets a completion flag or raises an interrupt, and drives the channel select and a power-down line to the core.

The all-ones channel code turns the converter off. After the converter leaves that state, the first conversion only lets the core settle. Its result is dropped and a second conversion starts at once. A control write that arrives while a conversion is running aborts it and starts a fresh one.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset, status reads 0x1F, the data register reads 0, irq_o is 0, power_down_o is 1 and no start pulse is issued. Status layout: bit 7 is the completion flag, bit 6 the interrupt enable, bit 5 the continuous bit and bits 4:0 the channel.
- R2: A control write with a channel other than 11111 makes conv_start_o high for exactly the one cycle after the write. chan_sel_o shows the written channel from that cycle on.
- R3: A done pulse for a running conversion loads conv_result_i into data_o at that clock edge. If interrupts are disabled, the same edge sets status bit 7.
- R4: While the interrupt enable is 1, status bit 7 always reads 0, and a completed conversion raises irq_o instead.
- R5: irq_o is cleared by a data-register read and by any control write.
- R6: With the continuous bit set, each captured result is followed by a new start pulse in the next cycle, and data_o is updated for every conversion.
- R7: With the continuous bit clear, one result is captured per write and no further start pulse follows.
- R8: Channel 11111 raises power_down_o and issues no start. While the converter is off, done pulses are ignored and data_o keeps its last value.
- R9: The first conversion after leaving channel 11111 is discarded: data_o and the flag do not change, and a new start pulse follows in the next cycle. The result of that second conversion is captured normally.
- R10: A control write during a running conversion clears the completion flag and issues a new start. Only the restarted conversion produces a result.
- R11: The value written to bit 7 has no effect; writing 1 there does not set the flag.
- R12: A data-register read clears the completion flag, unless a capture happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control write data |
| data_rd_i | input | 1 | Data register read strobe |
| status_o | output | 8 | Control and status readback |
| data_o | output | DATA_W | Data register |
| irq_o | output | 1 | Interrupt request |
| conv_start_o | output | 1 | Start pulse to the converter core |
| conv_done_i | input | 1 | Done pulse from the converter core |
| conv_result_i | input | DATA_W | Result from the converter core |
| chan_sel_o | output | 5 | Channel mux select |
| power_down_o | output | 1 | Converter power-down |

## Verification
Each result has a fixed arrival time after its stimulus. A start pulse is due in the cycle right after a write, or right after a done pulse that is discarded or that continues a run. The data register, the flag and irq_o change at the edge that samples the done, read or write strobe. The status readback is combinational from those registers. The bench applies every strobe for exactly one cycle between falling edges and samples at the next falling edge, which is the first point where the new value is due. It also samples start one cycle later to confirm that the pulse has ended.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned CHAN_W   = 5;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned IEN_BIT  = 6;
  localparam int unsigned CONT_BIT = 5;
  localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

  typedef struct packed {
    logic              ien;
    logic              cont;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_off_i,
  input  logic chan_off_i,
  input  logic cont_i,
  input  logic done_i,
  output logic start_o,
  output logic capture_o
);
  logic busy_q, warm_q, start_q;

  assign start_o   = start_q;
  assign capture_o = busy_q & done_i & ~warm_q & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      warm_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_i) begin
        if (wr_off_i) begin
          busy_q <= 1'b0;
          warm_q <= 1'b0;
        end else begin
          busy_q  <= 1'b1;
          start_q <= 1'b1;
          if (chan_off_i) warm_q <= 1'b1;  // leaving power-off
        end
      end else if (busy_q && done_i) begin
        if (warm_q) begin
          warm_q  <= 1'b0;
          start_q <= 1'b1;  // settle conversion done, run the real one
        end else if (cont_i) begin
          start_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  a_r9_discard_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && warm_q && done_i && !wr_i) |=> (start_o && !capture_o));

  a_r7_single_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !cont_i) |=> !start_o);

  a_r6_cont_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && cont_i) |=> start_o);
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] result_i,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] data_o
);
  ctrl_t             ctrl_q;
  logic              flag_q, irq_q;
  logic [DATA_W-1:0] data_q;

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{ien: 1'b0, cont: 1'b0, chan: CHAN_OFF};
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        // bit 7 of the write data is reserved and dropped
        ctrl_q.ien  <= wdata_i[IEN_BIT];
        ctrl_q.cont <= wdata_i[CONT_BIT];
        ctrl_q.chan <= wdata_i[CHAN_W-1:0];
        flag_q      <= 1'b0;
        irq_q       <= 1'b0;
      end else begin
        if (capture_i && !ctrl_q.ien) flag_q <= 1'b1;
        else if (rd_i)                flag_q <= 1'b0;
        if (capture_i && ctrl_q.ien)  irq_q  <= 1'b1;
        else if (rd_i)                irq_q  <= 1'b0;
      end
      if (capture_i) data_q <= result_i;
    end
  end

  a_r4_flag_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> !ctrl_q.ien);

  a_r5_irq_clr_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !irq_q);

  a_r12_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !capture_i && !wr_i) |=> !flag_q);
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              data_rd_i,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_result_i,
  output logic [4:0]        chan_sel_o,
  output logic              power_down_o
);
  ctrl_t ctrl;
  logic  flag, capture, wr_off;

  assign wr_off       = reg_wdata_i[CHAN_W-1:0] == CHAN_OFF;
  assign chan_sel_o   = ctrl.chan;
  assign power_down_o = ctrl.chan == CHAN_OFF;
  assign status_o     = {flag, ctrl.ien, ctrl.cont, ctrl.chan};

  adc_ctrl_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .wr_off_i   (wr_off),
    .chan_off_i (power_down_o),
    .cont_i     (ctrl.cont),
    .done_i     (conv_done_i),
    .start_o    (conv_start_o),
    .capture_o  (capture)
  );

  adc_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rd_i      (data_rd_i),
    .capture_i (capture),
    .result_i  (conv_result_i),
    .ctrl_o    (ctrl),
    .flag_o    (flag),
    .irq_o     (irq_o),
    .data_o    (data_o)
  );

  a_r2_start_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !wr_off) |=> conv_start_o);

  a_r8_off_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |-> !conv_start_o);

  a_r8_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |=> $stable(data_o));
endmodule

// File: tb/adc_ctrl_top_tb_top.sv
module adc_ctrl_top_tb_top;
  localparam int unsigned DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rd = 1'b0;
  logic [7:0]    status;
  logic [DW-1:0] data;
  logic          irq, start, done = 1'b0, pd;
  logic [DW-1:0] result = '0;
  logic [4:0]    chan;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  adc_ctrl_top #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .data_rd_i(rd), .status_o(status), .data_o(data), .irq_o(irq),
    .conv_start_o(start), .conv_done_i(done), .conv_result_i(result),
    .chan_sel_o(chan), .power_down_o(pd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic data_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic core_done(input logic [DW-1:0] r);
    @(negedge clk); done = 1'b1; result = r;
    @(negedge clk); done = 1'b0; result = '0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h1F);
    check("R1 data", data, 0);
    check("R1 irq", irq, 0);
    check("R1 power_down", pd, 1);
    check("R1 start", start, 0);
  endtask

  task automatic t_off_ignore();
    core_done(10'h155);
    check("R8 data held while off", data, 0);
    check("R8 flag while off", status[7], 0);
    check("R8 no start while off", start, 0);
  endtask

  task automatic t_powerup_single();
    reg_write(8'h03);
    check("R2 start pulse", start, 1);
    check("R2 chan_sel", chan, 5'h03);
    check("R8 power up", pd, 0);
    @(negedge clk);
    check("R2 start one cycle", start, 0);
    core_done(10'h111);
    check("R9 discard data", data, 0);
    check("R9 discard flag", status[7], 0);
    check("R9 restart", start, 1);
    core_done(10'h155);
    check("R3 capture", data, 10'h155);
    check("R3 flag", status[7], 1);
    check("R3 no irq", irq, 0);
    check("R7 no further start", start, 0);
    @(negedge clk);
    check("R7 still idle", start, 0);
  endtask

  task automatic t_read_clears();
    data_read();
    check("R12 flag cleared", status[7], 0);
    check("R12 data kept", data, 10'h155);
  endtask

  task automatic t_reserved_and_abort();
    reg_write(8'h84);
    check("R11 bit7 ignored", status, 8'h04);
    check("R2 start no warmup", start, 1);
    core_done(10'h0AA);
    check("R3 capture 2", data, 10'h0AA);
    check("R3 flag 2", status[7], 1);
    reg_write(8'h84);
    check("R10 write clears flag", status[7], 0);
    check("R10 start", start, 1);
    @(negedge clk);
    reg_write(8'h05);
    check("R10 abort restart", start, 1);
    check("R10 new chan", chan, 5'h05);
    core_done(10'h0CC);
    check("R10 capture", data, 10'h0CC);
    check("R10 single result", start, 0);
  endtask

  task automatic t_irq();
    reg_write(8'h41);
    core_done(10'h200);
    check("R4 irq raised", irq, 1);
    check("R4 flag hidden", status, 8'h41);
    check("R4 data", data, 10'h200);
    data_read();
    check("R5 irq clr by read", irq, 0);
    reg_write(8'h41);
    core_done(10'h201);
    check("R4 irq raised 2", irq, 1);
    reg_write(8'h41);
    check("R5 irq clr by write", irq, 0);
  endtask

  task automatic t_cont_and_off();
    reg_write(8'h22);
    check("R6 start", start, 1);
    core_done(10'h010);
    check("R6 data 1", data, 10'h010);
    check("R6 restart 1", start, 1);
    core_done(10'h020);
    check("R6 data 2", data, 10'h020);
    check("R6 restart 2", start, 1);
    reg_write(8'h1F);
    check("R8 power down", pd, 1);
    check("R8 no start", start, 0);
    core_done(10'h3FF);
    check("R8 data retained", data, 10'h020);
  endtask

  task automatic t_powerup_again();
    reg_write(8'h1E);
    check("R9 start", start, 1);
    core_done(10'h001);
    check("R9 discard 2", data, 10'h020);
    check("R9 flag 2", status[7], 0);
    check("R9 restart 2", start, 1);
    core_done(10'h002);
    check("R9 capture after settle", data, 10'h002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_ignore();
    t_powerup_single();
    t_read_clears();
    t_reserved_and_abort();
    t_irq();
    t_cont_and_off();
    t_powerup_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule